// File: doc/BRIEF.md
# Halfword Immediate Logic Unit

This unit executes the two-halfword logic instructions that combine a 16-bit immediate with one half of a 32-bit register. Eight encodings are accepted: AND into the upper half or the lower half, each with or without clearing the opposite half, plus OR and exclusive-OR into either half. The execute stage presents the 32-bit instruction word, the value read for the named register and the address of the instruction. One cycle later the unit returns the 32-bit result, a register write enable, new negative and zero flags, and a branch request.

The first halfword of the instruction sits in `insn_i[31:16]` and the immediate fills `insn_i[15:0]`. The low four bits of the first halfword name the register. That register is both the source and the destination. When the field names register 15, the unit takes the instruction address as the operand instead of the register value. The result then goes out as a branch target rather than as a register write.

Top module: `hli_unit`

## Requirements
- R1: While `rst_ni` is low and after reset, `valid_o`, `wr_en_o`, `branch_o`, `flag_n_o` and `flag_z_o` are 0, and `result_o` and `rd_o` are all zeros.
- R2: An accepted instruction raises `valid_o` for exactly one cycle, on the clock edge after the one that samples `valid_i`. An instruction counts as accepted when `valid_i` is high and `insn_i[31:20]` holds one of the eight opcodes listed in R3 to R6.
- R3: AND-high is opcode 0xE41 (clear bit 0) or 0xE61 (clear bit 1); bit 25 is the clear bit. The upper half becomes operand[31:16] & imm. With clear bit 0 the lower half is kept; with clear bit 1 it becomes zero.
- R4: AND-low is opcode 0xE01 (clear bit 0) or 0xE21 (clear bit 1). The lower half becomes operand[15:0] & imm. With clear bit 0 the upper half is kept; with clear bit 1 it becomes zero.
- R5: OR-high is opcode 0xEA1 and ORs the immediate into the upper half. OR-low is opcode 0xE81 and ORs it into the lower half. The other half is kept in both cases.
- R6: EOR-high is opcode 0xEE1 and EOR-low is opcode 0xEC1. Each exclusive-ORs the immediate into its half and keeps the other half.
- R7: Every accepted instruction sets `flag_n_o` to bit 31 of the result. It sets `flag_z_o` to 1 exactly when all 32 result bits are zero.
- R8: When `insn_i[19:16]` is 15, the operand is `pc_i`. The unit then raises `branch_o`, keeps `wr_en_o` at 0 and presents the target on `result_o`.
- R9: When `insn_i[19:16]` is not 15, the operand is `rs_val_i`. The unit then raises `wr_en_o`, keeps `branch_o` at 0 and copies the field to `rd_o`.
- R10: An idle cycle or an unrecognised opcode leaves `valid_o`, `wr_en_o` and `branch_o` at 0. It also leaves `result_o`, `rd_o` and both flags at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | First halfword in [31:16], immediate in [15:0] |
| rs_val_i | input | 32 | Value of the named register |
| pc_i | input | 32 | Address of the instruction |
| valid_o | output | 1 | Result and flags are to be committed |
| wr_en_o | output | 1 | Write `result_o` to register `rd_o` |
| branch_o | output | 1 | Load `result_o` into the program counter |
| rd_o | output | 4 | Destination register |
| result_o | output | 32 | Computed value or branch target |
| flag_n_o | output | 1 | New negative flag |
| flag_z_o | output | 1 | New zero flag |

## Verification
Every output register is loaded on the edge after the instruction, so a wrong decode, a half mask built for the wrong half or a stale clear bit shows up in the result one cycle after the strobe. A flag register that does not follow its result shows in the same cycle, as does a write enable that should have been a branch. A register that is loaded when it should hold is caught on the next idle or rejected cycle, because `result_o`, `rd_o` and the flags then change while `valid_o` stays low.

// File: rtl/hli_pkg.sv
package hli_pkg;

  localparam int OPC_W = 12;

  // first-halfword opcodes, bits [15:4]
  localparam logic [OPC_W-1:0] OPC_ANDH_KEEP = 12'hE41;
  localparam logic [OPC_W-1:0] OPC_ANDH_CLR  = 12'hE61;
  localparam logic [OPC_W-1:0] OPC_ANDL_KEEP = 12'hE01;
  localparam logic [OPC_W-1:0] OPC_ANDL_CLR  = 12'hE21;
  localparam logic [OPC_W-1:0] OPC_EORH      = 12'hEE1;
  localparam logic [OPC_W-1:0] OPC_EORL      = 12'hEC1;
  localparam logic [OPC_W-1:0] OPC_ORH       = 12'hEA1;
  localparam logic [OPC_W-1:0] OPC_ORL       = 12'hE81;

  typedef enum logic [1:0] {
    LOP_AND  = 2'd0,
    LOP_OR   = 2'd1,
    LOP_EOR  = 2'd2,
    LOP_NONE = 2'd3
  } lop_e;

  typedef struct packed {
    logic hit;
    lop_e op;
    logic upper;
    logic clr;
  } dec_t;

endpackage

// File: rtl/hli_decode.sv
module hli_decode
  import hli_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);

  always_comb begin
    dec_o = '{hit: 1'b1, op: LOP_AND, upper: 1'b0, clr: 1'b0};
    unique case (opc_i)
      OPC_ANDH_KEEP: begin dec_o.upper = 1'b1; end
      OPC_ANDH_CLR:  begin dec_o.upper = 1'b1; dec_o.clr = 1'b1; end
      OPC_ANDL_KEEP: ;
      OPC_ANDL_CLR:  begin dec_o.clr = 1'b1; end
      OPC_EORH:      begin dec_o.op = LOP_EOR; dec_o.upper = 1'b1; end
      OPC_EORL:      begin dec_o.op = LOP_EOR; end
      OPC_ORH:       begin dec_o.op = LOP_OR; dec_o.upper = 1'b1; end
      OPC_ORL:       begin dec_o.op = LOP_OR; end
      default:       begin dec_o.hit = 1'b0; dec_o.op = LOP_NONE; end
    endcase
  end

endmodule

// File: rtl/hli_halfop.sv
module hli_halfop
  import hli_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  lop_e                  op_i,
  input  logic                  upper_i,
  input  logic                  clr_i,
  input  logic [2*HALF_W-1:0]   opnd_i,
  input  logic [HALF_W-1:0]     imm_i,
  output logic [2*HALF_W-1:0]   res_o
);

  localparam int W = 2 * HALF_W;

  logic [HALF_W-1:0] fill;
  logic [W-1:0]      mask;

  // untouched half: ones for a keeping AND, zeros otherwise
  always_comb fill = (op_i == LOP_AND && !clr_i) ? '1 : '0;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam bit IS_UPPER = (h == 1);
    assign mask[h*HALF_W +: HALF_W] = (upper_i == IS_UPPER) ? imm_i : fill;
  end

  always_comb begin
    unique case (op_i)
      LOP_AND: res_o = opnd_i & mask;
      LOP_OR:  res_o = opnd_i | mask;
      LOP_EOR: res_o = opnd_i ^ mask;
      default: res_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/hli_flags.sv
module hli_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         n_o,
  output logic         z_o
);

  assign n_o = val_i[W-1];
  assign z_o = ~|val_i;

endmodule

// File: rtl/hli_unit.sv
module hli_unit
  import hli_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int REG_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*HALF_W-1:0]   insn_i,
  input  logic [2*HALF_W-1:0]   rs_val_i,
  input  logic [2*HALF_W-1:0]   pc_i,
  output logic                  valid_o,
  output logic                  wr_en_o,
  output logic                  branch_o,
  output logic [REG_W-1:0]      rd_o,
  output logic [2*HALF_W-1:0]   result_o,
  output logic                  flag_n_o,
  output logic                  flag_z_o
);

  localparam int              W       = 2 * HALF_W;
  localparam logic [REG_W-1:0] PC_IDX = '1;

  logic [HALF_W-1:0] hw1, imm;
  logic [REG_W-1:0]  rd;
  logic              to_pc, accept;
  logic [W-1:0]      opnd, res;
  logic              n_d, z_d;
  dec_t              dec;

  assign hw1    = insn_i[W-1:HALF_W];
  assign imm    = insn_i[HALF_W-1:0];
  assign rd     = hw1[REG_W-1:0];
  assign to_pc  = (rd == PC_IDX);
  assign opnd   = to_pc ? pc_i : rs_val_i;
  assign accept = valid_i & dec.hit;

  hli_decode u_dec (
    .opc_i (hw1[HALF_W-1 -: OPC_W]),
    .dec_o (dec)
  );

  hli_halfop #(.HALF_W(HALF_W)) u_op (
    .op_i    (dec.op),
    .upper_i (dec.upper),
    .clr_i   (dec.clr),
    .opnd_i  (opnd),
    .imm_i   (imm),
    .res_o   (res)
  );

  hli_flags #(.W(W)) u_flg (
    .val_i (res),
    .n_o   (n_d),
    .z_o   (z_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      branch_o <= 1'b0;
      rd_o     <= '0;
      result_o <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
    end else begin
      valid_o  <= accept;
      wr_en_o  <= accept & ~to_pc;
      branch_o <= accept & to_pc;
      if (accept) begin
        rd_o     <= rd;
        result_o <= res;
        flag_n_o <= n_d;
        flag_z_o <= z_d;
      end
    end
  end

endmodule

// File: rtl/hli_unit_chk.sv
module hli_unit_chk #(
  parameter int HALF_W = 16,
  parameter int REG_W  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                valid_o,
  input logic                wr_en_o,
  input logic                branch_o,
  input logic [REG_W-1:0]    rd_o,
  input logic [2*HALF_W-1:0] result_o,
  input logic                flag_n_o,
  input logic                flag_z_o
);

  localparam logic [REG_W-1:0] PC_IDX = '1;

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  assert_zero_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_z_o == (result_o == '0)));

  assert_neg_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_n_o == result_o[2*HALF_W-1]));

  assert_branch_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> (valid_o && !wr_en_o && rd_o == PC_IDX));

  assert_write_gpr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (valid_o && !branch_o && rd_o != PC_IDX));

  assert_one_of_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot({wr_en_o, branch_o}));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(rd_o) && $stable(flag_n_o) && $stable(flag_z_o)));

endmodule

bind hli_unit hli_unit_chk #(.HALF_W(HALF_W), .REG_W(REG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .wr_en_o  (wr_en_o),
  .branch_o (branch_o),
  .rd_o     (rd_o),
  .result_o (result_o),
  .flag_n_o (flag_n_o),
  .flag_z_o (flag_z_o)
);

// File: tb/tb_hli_unit.sv
`timescale 1ns/1ps
module tb_hli_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0, rs_val_i = '0, pc_i = '0;
  logic        valid_o, wr_en_o, branch_o, flag_n_o, flag_z_o;
  logic [3:0]  rd_o;
  logic [31:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;

  // expected state
  bit          e_valid = 0, e_wr = 0, e_br = 0, e_n = 0, e_z = 0;
  logic [3:0]  e_rd = '0;
  logic [31:0] e_res = '0;
  string       e_tag = "R1";

  always #2 clk = ~clk;

  hli_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .rs_val_i(rs_val_i), .pc_i(pc_i), .valid_o(valid_o), .wr_en_o(wr_en_o),
    .branch_o(branch_o), .rd_o(rd_o), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(input logic [31:0] ins, input logic [31:0] rv, input logic [31:0] pcv,
                                output bit hit, output logic [31:0] res, output string tag);
    logic [15:0] imm = ins[15:0];
    logic [3:0]  rd  = ins[19:16];
    logic [31:0] a   = (rd == 4'd15) ? pcv : rv;
    hit = 1;
    res = a;
    tag = "R10";
    case (ins[31:20])
      12'hE41: begin res = a & {imm, 16'hFFFF}; tag = "R3"; end
      12'hE61: begin res = a & {imm, 16'h0000}; tag = "R3"; end
      12'hE01: begin res = a & {16'hFFFF, imm}; tag = "R4"; end
      12'hE21: begin res = a & {16'h0000, imm}; tag = "R4"; end
      12'hEA1: begin res = a | {imm, 16'h0000}; tag = "R5"; end
      12'hE81: begin res = a | {16'h0000, imm}; tag = "R5"; end
      12'hEE1: begin res = a ^ {imm, 16'h0000}; tag = "R6"; end
      12'hEC1: begin res = a ^ {16'h0000, imm}; tag = "R6"; end
      default: hit = 0;
    endcase
    if (hit && rd == 4'd15) tag = {tag, "/R8"};
  endfunction

  task automatic compare();
    string hold = e_valid ? "" : (e_tag == "R1" ? "R1" : "R10");
    chk(valid_o == e_valid, e_valid ? "R2 valid" : {hold, " valid"}, 32'(valid_o), 32'(e_valid));
    chk(wr_en_o == e_wr, e_valid ? "R9 wr_en" : {hold, " wr_en"}, 32'(wr_en_o), 32'(e_wr));
    chk(branch_o == e_br, e_valid ? "R8 branch" : {hold, " branch"}, 32'(branch_o), 32'(e_br));
    chk(rd_o == e_rd, e_valid ? "R9 rd" : {hold, " rd"}, 32'(rd_o), 32'(e_rd));
    chk(result_o == e_res, e_valid ? {e_tag, " result"} : {hold, " result"}, result_o, e_res);
    chk(flag_n_o == e_n, e_valid ? "R7 n" : {hold, " n"}, 32'(flag_n_o), 32'(e_n));
    chk(flag_z_o == e_z, e_valid ? "R7 z" : {hold, " z"}, 32'(flag_z_o), 32'(e_z));
  endtask

  task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] rv, input logic [31:0] pcv);
    bit hit;
    logic [31:0] res;
    string tag;
    @(negedge clk);
    compare();
    valid_i  = v;
    insn_i   = ins;
    rs_val_i = rv;
    pc_i     = pcv;
    model(ins, rv, pcv, hit, res, tag);
    if (v && hit) begin
      e_valid = 1;
      e_rd    = ins[19:16];
      e_wr    = (ins[19:16] != 4'd15);
      e_br    = (ins[19:16] == 4'd15);
      e_res   = res;
      e_n     = res[31];
      e_z     = (res == 32'h0);
      e_tag   = tag;
    end else begin
      e_valid = 0;
      e_wr    = 0;
      e_br    = 0;
      if (e_tag == "R1" && !v) e_tag = "R1";
      else e_tag = "R10";
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [11:0] codes [8] = '{12'hE41, 12'hE61, 12'hE01, 12'hE21,
                               12'hEA1, 12'hE81, 12'hEE1, 12'hEC1};
    logic [11:0] bad   [8] = '{12'hE43, 12'hE51, 12'hEF1, 12'hE11,
                               12'hE91, 12'hEC0, 12'h000, 12'hFFF};
    logic [3:0]  rds   [4] = '{4'd0, 4'd5, 4'd14, 4'd15};
    repeat (3) @(negedge clk);
    // R1: reset values while reset held
    chk(valid_o == 0 && wr_en_o == 0 && branch_o == 0, "R1 strobes", {29'd0, valid_o, wr_en_o, branch_o}, 32'd0);
    chk(result_o == 0 && rd_o == 0, "R1 data", result_o, 32'd0);
    chk(flag_n_o == 0 && flag_z_o == 0, "R1 flags", {30'd0, flag_n_o, flag_z_o}, 32'd0);
    rst_ni = 1'b1;
    step(0, 32'hE41F_0000, 32'hFFFF_FFFF, 32'h0);
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 4; r++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] opv, pcv;
          logic [15:0] imm;
          case (p)
            0: begin opv = 32'h0000_0000; imm = 16'hFFFF; end
            1: begin opv = 32'hFFFF_FFFF; imm = 16'h0000; end
            2: begin opv = 32'h8000_0000; imm = 16'h8000; end
            3: begin opv = 32'h1234_5678; imm = 16'hA55A; end
            default: begin opv = $urandom; imm = 16'($urandom); end
          endcase
          pcv = (p == 1) ? 32'hFFFF_FFFF : {$urandom} & 32'hFFFF_FFFE;
          step(1, {codes[c], rds[r], imm}, opv, pcv);
          if (p == 3) begin
            // idle with changing inputs: outputs must hold (R10)
            step(0, {codes[c], rds[r], 16'h1234}, ~opv, ~pcv);
          end
        end
      end
    end
    // R10: unrecognised opcodes with valid high
    for (int b = 0; b < 8; b++) begin
      step(1, {bad[b], 4'd3, 16'h5A5A}, 32'hDEAD_BEEF, 32'h0000_1000);
    end
    // back-to-back mix after rejects
    for (int k = 0; k < 40; k++) begin
      logic [31:0] w = $urandom;
      step(1, {codes[k % 8], w[19:0]}, $urandom, $urandom);
    end
    step(0, 32'h0, 32'h0, 32'h0);
    step(0, 32'h0, 32'h0, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule